// File: doc/BRIEF.md
# RTC Register and Interrupt Controller

This block is the byte-wide register front end of a real-time clock. It sits between a simple synchronous read/write port and a separate time-keeping counter. It holds the alarm time and the control, status, interrupt-enable and compensation bytes. It keeps a frozen copy of the running time so that software can read all seven time bytes coherently. It drives a single interrupt line.

The counter block is reached only through ports. It presents its live time and one-cycle event pulses for each second, minute, hour and day boundary. This block returns a load strobe with a new time and the run and mode bits. To set the clock, software writes the six time bytes into a shadow copy, and the write of the year byte loads all six into the counter in one cycle. To read the clock, software writes the snapshot command and then reads the frozen bytes, in a single burst if it wishes, using the auto-incrementing address.

Top module: `rtc_regbank`

## Requirements
- R1: After reset, status (0x0E) reads 0x80, control (0x0D) and interrupt enables (0x0F) read 0x00, and `run`, `irq` and `ld_stb` are low.
- R2: Control bits 5:0 read back as written. Bit 0 drives `run`, and `mode_bits` carries control bits 5:1. Control bit 6 always reads 0. Status bit 1 mirrors `run`, and status bit 0 reads 0.
- R3: Writing control with bit 6 set copies `live_time` (byte k, bits 8k+7:8k, k = 0 seconds up to 6 weekday) into the readable time bytes at 0x00–0x06. Those bytes do not change until the next such write.
- R4: Writes to 0x00–0x04 only update a shadow copy. A write to 0x05 raises `ld_stb` for one cycle in the next cycle, with `ld_time` holding all six shadow bytes (0x00 in bits 7:0 up to 0x05 in bits 47:40).
- R5: A pulse on `tick_sec`, `tick_min`, `tick_hour` or `tick_day` sets status bit 2, 3, 4 or 5 respectively. The bit stays set until a status write with a 1 in that position, and a 0 in a status write leaves the bit unchanged.
- R6: Status bit 6 (alarm) is set in the cycle after `live_time` bits 47:0 become equal to the alarm bytes at 0x07–0x0C (seconds in 0x07). It stays set until software writes 1 to it, and it does not set again while the match persists.
- R7: Status bit 7 (power-up) is set only by reset and is cleared by writing 1 to it. Writing 0 leaves it set.
- R8: `irq` = (alarm flag AND enable bit 3) OR (selected event flag AND enable bit 2). Enable bits 1:0 select the event: 0 second, 1 minute, 2 hour, 3 day. Enable bits 7:4 read as 0.
- R9: An access with `seq` high uses the previous access address plus one in place of `addr`. This allows burst reads and writes.
- R10: Writes to 0x06 and to 0x12–0x1F have no effect. Reads from 0x12–0x1F return 0x00.
- R11: Alarm bytes (0x07–0x0C) and compensation bytes (0x10 low, 0x11 high) read back as written. `comp_val` carries {0x11, 0x10}.
- R12: Read data appears on `rdata` at the clock edge that samples the read access, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe for one cycle |
| wr_en | input | 1 | 1 = write, 0 = read, when acc_en is high |
| seq | input | 1 | Use the auto-incremented address for this access |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| live_time | input | 56 | Running time from the counter, seconds in the low byte, weekday in the high byte |
| ld_time | output | 48 | Time to load into the counter |
| ld_stb | output | 1 | One-cycle load strobe |
| run | output | 1 | Counter run enable |
| mode_bits | output | 5 | Rounding, auto-compensation, 12/24 h, test and 32 kHz-load controls |
| comp_val | output | 16 | Compensation value |
| tick_sec | input | 1 | Second boundary pulse |
| tick_min | input | 1 | Minute boundary pulse |
| tick_hour | input | 1 | Hour boundary pulse |
| tick_day | input | 1 | Day boundary pulse |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is an alarm flag cleared by software while the live time still equals the alarm time. Only an edge-detected match keeps the flag from coming straight back in that state. The bench drives the counter's time up to the alarm value and holds it there. It then writes 1 to status bit 6 and checks that the flag and `irq` stay low. A second hard case is a coherent burst read: the bench snapshots one time, changes the live time, and walks all seven bytes with `seq` to show the frozen values.

// File: rtl/rtc_regbank.sv
module rtc_regbank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        wr_en,
  input  logic        seq,
  input  logic [4:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [55:0] live_time,
  output logic [47:0] ld_time,
  output logic        ld_stb,
  output logic        run,
  output logic [4:0]  mode_bits,
  output logic [15:0] comp_val,
  input  logic        tick_sec,
  input  logic        tick_min,
  input  logic        tick_hour,
  input  logic        tick_day,
  output logic        irq
);
  logic [4:0]  ptr, cur_addr;
  logic [2:0]  aidx;
  logic [55:0] snap;
  logic [47:0] shadow, alarm_v;
  logic [5:0]  ctrl;
  logic [3:0]  ien, ev_f;
  logic        alm_f, pwr_f, match, match_q;
  logic [7:0]  comp_lo, comp_hi, rmux;
  logic        wr, rd, st_wr;

  assign cur_addr  = seq ? ptr : addr;
  assign aidx      = cur_addr[2:0] - 3'd7;
  assign wr        = acc_en & wr_en;
  assign rd        = acc_en & ~wr_en;
  assign st_wr     = wr & (cur_addr == 5'd14);
  assign match     = (live_time[47:0] == alarm_v);
  assign ld_time   = shadow;
  assign run       = ctrl[0];
  assign mode_bits = ctrl[5:1];
  assign comp_val  = {comp_hi, comp_lo};
  assign irq       = (alm_f & ien[3]) | (ev_f[ien[1:0]] & ien[2]);

  always_comb begin
    rmux = 8'h00;
    if (cur_addr <= 5'd6)
      rmux = snap[{cur_addr[2:0], 3'b000} +: 8];
    else if (cur_addr <= 5'd12)
      rmux = alarm_v[{aidx, 3'b000} +: 8];
    else if (cur_addr == 5'd13)
      rmux = {2'b00, ctrl};
    else if (cur_addr == 5'd14)
      rmux = {pwr_f, alm_f, ev_f, run, 1'b0};
    else if (cur_addr == 5'd15)
      rmux = {4'h0, ien};
    else if (cur_addr == 5'd16)
      rmux = comp_lo;
    else if (cur_addr == 5'd17)
      rmux = comp_hi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= 5'd0;
      snap    <= '0;
      shadow  <= '0;
      alarm_v <= '0;
      ctrl    <= '0;
      ien     <= '0;
      ev_f    <= '0;
      alm_f   <= 1'b0;
      pwr_f   <= 1'b1;
      match_q <= 1'b1;
      comp_lo <= '0;
      comp_hi <= '0;
      rdata   <= '0;
      ld_stb  <= 1'b0;
    end else begin
      match_q <= match;
      ld_stb  <= wr && (cur_addr == 5'd5);
      if (acc_en) ptr <= cur_addr + 5'd1;
      if (rd) rdata <= rmux;
      if (wr && cur_addr <= 5'd5)
        shadow[{cur_addr[2:0], 3'b000} +: 8] <= wdata;
      if (wr && cur_addr >= 5'd7 && cur_addr <= 5'd12)
        alarm_v[{aidx, 3'b000} +: 8] <= wdata;
      if (wr && cur_addr == 5'd13) begin
        ctrl <= wdata[5:0];
        if (wdata[6]) snap <= live_time;
      end
      if (wr && cur_addr == 5'd15) ien <= wdata[3:0];
      if (wr && cur_addr == 5'd16) comp_lo <= wdata;
      if (wr && cur_addr == 5'd17) comp_hi <= wdata;
      ev_f  <= (ev_f & ~(st_wr ? wdata[5:2] : 4'h0))
             | {tick_day, tick_hour, tick_min, tick_sec};
      alm_f <= (alm_f & ~(st_wr & wdata[6])) | (match & ~match_q);
      pwr_f <= pwr_f & ~(st_wr & wdata[7]);
    end
  end
endmodule

module rtc_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_en,
  input logic       wr_en,
  input logic [4:0] cur_addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       ld_stb,
  input logic       run,
  input logic       irq,
  input logic [3:0] ien,
  input logic       alm_f,
  input logic       pwr_f
);
  p_ld_from_year_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |-> $past(acc_en && wr_en && cur_addr == 5'd5));
  p_run_follows_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && wr_en && cur_addr == 5'd13) |=> (run == $past(wdata[0])));
  p_alarm_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_f && !(acc_en && wr_en && cur_addr == 5'd14 && wdata[6])) |=> alm_f);
  p_powerup_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_f && !(acc_en && wr_en && cur_addr == 5'd14 && wdata[7])) |=> pwr_f);
  p_powerup_no_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_f |=> !pwr_f);
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !wr_en && cur_addr >= 5'd18) |=> (rdata == 8'h00));
  p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien[3] || ien[2]));
endmodule

bind rtc_regbank rtc_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_en(wr_en),
  .cur_addr(cur_addr), .wdata(wdata), .rdata(rdata), .ld_stb(ld_stb),
  .run(run), .irq(irq), .ien(ien), .alm_f(alm_f), .pwr_f(pwr_f)
);

// File: tb/rtc_regbank_test.sv
module rtc_regbank_test;
  logic clk = 1'b0, rst_n = 1'b0, acc_en = 1'b0, wr_en = 1'b0, seq = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic [55:0] live_time = '0;
  logic [47:0] ld_time;
  logic        ld_stb, run, irq;
  logic [4:0]  mode_bits;
  logic [15:0] comp_val;
  logic tick_sec = 0, tick_min = 0, tick_hour = 0, tick_day = 0;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_regbank uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_en(wr_en), .seq(seq),
    .addr(addr), .wdata(wdata), .rdata(rdata), .live_time(live_time),
    .ld_time(ld_time), .ld_stb(ld_stb), .run(run), .mode_bits(mode_bits),
    .comp_val(comp_val), .tick_sec(tick_sec), .tick_min(tick_min),
    .tick_hour(tick_hour), .tick_day(tick_day), .irq(irq));

  // op(1=write), addr, data (expected data for reads)
  localparam logic [13:0] VEC [31] = '{
    {1'b1,5'd7,8'h59}, {1'b0,5'd7,8'h59}, {1'b1,5'd8,8'h45}, {1'b0,5'd8,8'h45},
    {1'b1,5'd9,8'h23}, {1'b1,5'd10,8'h31}, {1'b1,5'd11,8'h12}, {1'b1,5'd12,8'h99},
    {1'b0,5'd9,8'h23}, {1'b0,5'd10,8'h31}, {1'b0,5'd11,8'h12}, {1'b0,5'd12,8'h99},
    {1'b1,5'd16,8'hA5}, {1'b1,5'd17,8'h3C}, {1'b0,5'd16,8'hA5}, {1'b0,5'd17,8'h3C},
    {1'b1,5'd15,8'hFB}, {1'b0,5'd15,8'h0B}, {1'b1,5'd15,8'h00}, {1'b0,5'd15,8'h00},
    {1'b1,5'd13,8'h3F}, {1'b0,5'd13,8'h3F}, {1'b1,5'd13,8'h7E}, {1'b0,5'd13,8'h3E},
    {1'b1,5'd18,8'h55}, {1'b0,5'd18,8'h00}, {1'b0,5'd31,8'h00}, {1'b1,5'd6,8'h77},
    {1'b0,5'd6,8'h00}, {1'b1,5'd13,8'h00}, {1'b0,5'd13,8'h00}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic s);
    @(negedge clk);
    acc_en = 1; wr_en = 1; addr = a; wdata = d; seq = s;
    @(negedge clk);
    acc_en = 0; wr_en = 0; seq = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic s, output logic [7:0] d);
    @(negedge clk);
    acc_en = 1; wr_en = 0; addr = a; seq = s;
    @(negedge clk);
    acc_en = 0; seq = 0;
    d = rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: tick_sec = 1;
      1: tick_min = 1;
      2: tick_hour = 1;
      default: tick_day = 1;
    endcase
    @(negedge clk);
    tick_sec = 0; tick_min = 0; tick_hour = 0; tick_day = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 run", run, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ld_stb", ld_stb, 0);
    rd(5'd14, 0, d); chk("R1 status", d, 8'h80);
    rd(5'd13, 0, d); chk("R1 ctrl", d, 8'h00);
    rd(5'd15, 0, d); chk("R1 ien", d, 8'h00);
    // R7 power-up flag
    wr(5'd14, 8'h00, 0); rd(5'd14, 0, d); chk("R7 write0 keeps", d, 8'h80);
    wr(5'd14, 8'h80, 0); rd(5'd14, 0, d); chk("R7 w1c", d, 8'h00);
    // vector walk (R11 R12 R10 R2)
    for (int i = 0; i < 31; i++) begin
      if (VEC[i][13]) wr(VEC[i][12:8], VEC[i][7:0], 0);
      else begin
        rd(VEC[i][12:8], 0, d);
        chk((VEC[i][12:8] == 5'd13) ? "R2 table" :
            (VEC[i][12:8] >= 5'd18 || VEC[i][12:8] == 5'd6) ? "R10 table" : "R11 R12 table",
            d, VEC[i][7:0]);
      end
    end
    chk("R11 comp_val", comp_val, 16'h3CA5);
    // R2 run and mode bits
    wr(5'd13, 8'h2B, 0);
    chk("R2 run", run, 1);
    chk("R2 mode_bits", mode_bits, 5'h15);
    wr(5'd13, 8'h01, 0);
    rd(5'd14, 0, d); chk("R2 status run", d, 8'h02);
    // R3 snapshot + R9 burst read
    live_time = 56'h04_23_05_17_10_42_07;
    wr(5'd13, 8'h41, 0);
    live_time = 56'h02_11_11_11_11_11_11;
    rd(5'd0, 0, d); chk("R3 sec", d, 8'h07);
    rd(5'd0, 1, d); chk("R9 burst min", d, 8'h42);
    rd(5'd0, 1, d); chk("R9 burst hour", d, 8'h10);
    rd(5'd0, 1, d); chk("R9 burst day", d, 8'h17);
    rd(5'd0, 1, d); chk("R9 burst month", d, 8'h05);
    rd(5'd0, 1, d); chk("R9 burst year", d, 8'h23);
    rd(5'd0, 1, d); chk("R3 weekday", d, 8'h04);
    rd(5'd13, 0, d); chk("R2 ctrl bit6 reads 0", d, 8'h01);
    // R4 shadow and load
    wr(5'd0, 8'h11, 0); chk("R4 no load sec", ld_stb, 0);
    wr(5'd0, 8'h22, 1); chk("R4 no load min", ld_stb, 0);
    wr(5'd0, 8'h33, 1);
    wr(5'd0, 8'h44, 1);
    wr(5'd0, 8'h55, 1); chk("R4 no load month", ld_stb, 0);
    wr(5'd0, 8'h66, 1);
    chk("R4 load strobe", ld_stb, 1);
    chk("R4 load value", ld_time, 48'h66_55_44_33_22_11);
    @(negedge clk); chk("R4 strobe one cycle", ld_stb, 0);
    rd(5'd0, 0, d); chk("R4 shadow not read", d, 8'h07);
    // R5 / R8 events
    wr(5'd15, 8'h05, 0);
    pulse(0); chk("R8 unselected event", irq, 0);
    rd(5'd14, 0, d); chk("R5 sec flag", d, 8'h06);
    pulse(1); chk("R8 minute irq", irq, 1);
    rd(5'd14, 0, d); chk("R5 min flag", d, 8'h0E);
    wr(5'd14, 8'h08, 0); chk("R8 irq drops", irq, 0);
    rd(5'd14, 0, d); chk("R5 w1c minute", d, 8'h06);
    pulse(2); pulse(3);
    wr(5'd14, 8'h00, 0);
    rd(5'd14, 0, d); chk("R5 write0 keeps", d, 8'h36);
    wr(5'd15, 8'h07, 0); chk("R8 day irq", irq, 1);
    wr(5'd14, 8'h3C, 0); chk("R8 cleared", irq, 0);
    rd(5'd14, 0, d); chk("R5 all cleared", d, 8'h02);
    // R6 alarm
    wr(5'd15, 8'h08, 0); chk("R8 no alarm yet", irq, 0);
    @(negedge clk); live_time = 56'h01_99_12_31_23_45_59;
    @(negedge clk); chk("R6 alarm irq", irq, 1);
    repeat (3) @(negedge clk);
    rd(5'd14, 0, d); chk("R6 alarm flag", d, 8'h42);
    wr(5'd14, 8'h40, 0); chk("R6 cleared under match", irq, 0);
    repeat (3) @(negedge clk);
    rd(5'd14, 0, d); chk("R6 no retrigger", d, 8'h02);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule